// File: doc/BRIEF.md
# Link Start-Up Supervisor

This controller brings up one end of a full-duplex point-to-point link and then watches over it. After reset it keeps both the transmitter and the receiver quiet for a short settling time. It then enables only the receiver for a longer listening time, so the far end has a chance to come up as well. After that it waits for software to permit the link.

Once permitted, the link is built in two timed handshake stages. In the first stage the block asks its transmitter to send NULL characters and waits a bounded time for a NULL to arrive from the far end. In the second stage it also asks for flow-control tokens (FCTs) and waits a bounded time for an FCT to arrive. When both stages succeed the link runs and the `active` flag is raised. Any receiver error, a disable request while running, or a handshake window that runs out drops the link back to the quiet reset state, and bring-up starts again.

All timing windows are derived from the clock-frequency parameter `CLK_MHZ`. The settling time is 6.4 µs, or RST_CYC = CLK_MHZ*64/10 cycles. Each of the listening and handshake windows is 12.8 µs, or LONG_CYC = CLK_MHZ*128/10 cycles. A single down-counter is shared by all states and is reloaded on every state change. Character coding, FIFOs and the line itself are handled elsewhere.

Top module: `link_init_fsm`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, all five outputs (`tx_en`, `rx_en`, `send_null`, `send_fct`, `active`) are low.
- R2: The quiet reset state lasts exactly RST_CYC clock edges, both after `rst` and after any drop back to it. On the last of these edges `rx_en` rises while `tx_en` stays low.
- R3: The listening state (`rx_en`=1, all other outputs 0) lasts exactly LONG_CYC edges and ignores `link_en`. After it the block is in the permit state, which has the same outputs.
- R4: In the permit state the block stays indefinitely while `link_en` is low. The first edge that samples `link_en` high moves it to the NULL stage.
- R5: The NULL stage drives `tx_en`, `rx_en` and `send_null` high and `send_fct` and `active` low. An edge that samples `null_rx` high moves the block to the FCT stage.
- R6: If no NULL is seen, the NULL stage ends after exactly LONG_CYC edges with a drop to the quiet reset state.
- R7: The FCT stage drives `tx_en`, `rx_en`, `send_null` and `send_fct` high. An edge that samples `fct_rx` moves the block to run. If no FCT is seen, the stage drops to reset after exactly LONG_CYC edges.
- R8: In run, `active`, `tx_en` and `rx_en` are high and `send_null` and `send_fct` are low. The block stays in run for as long as no error and no disable is seen.
- R9: Any set bit of `err`, sampled in any state other than quiet reset, drops the block to quiet reset on that edge. During quiet reset, `err` is ignored and does not lengthen the reset.
- R10: `link_dis` drops the block from run to quiet reset on the edge that samples it. Outside run it has no effect.
- R11: In the NULL stage, `fct_rx` is ignored. A NULL (or an FCT in the FCT stage) that arrives on the same edge the window expires wins over the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| link_en | input | 1 | Permission to start bring-up |
| link_dis | input | 1 | Request to tear down a running link |
| null_rx | input | 1 | Receiver saw a NULL character this cycle |
| fct_rx | input | 1 | Receiver saw an FCT this cycle |
| err | input | ERR_W | Receiver error flags, any bit set is an error |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| send_null | output | 1 | Ask transmitter to send NULLs |
| send_fct | output | 1 | Ask transmitter to send FCTs |
| active | output | 1 | Link is running |

## Verification
The properties assume that `null_rx`, `fct_rx`, `err`, `link_en` and `link_dis` are synchronous to `clk` and already qualified by the receiver. A single-cycle pulse is therefore a full event, and nothing has to be filtered. The stimulus changes these inputs only at falling edges and holds each pattern for a whole number of cycles. Handshake characters are presented only for the cycles in which the bench means them to count, so that every state change can be attributed to one sampled edge. The bench shortens all windows by instantiating the block with a small `CLK_MHZ`, which keeps the timeout edges at exact, countable cycles.

// File: rtl/link_init_pkg.sv
package link_init_pkg;

    typedef enum logic [2:0] {
        LS_RESET = 3'd0,
        LS_WAIT  = 3'd1,
        LS_READY = 3'd2,
        LS_START = 3'd3,
        LS_CONN  = 3'd4,
        LS_RUN   = 3'd5
    } lstate_e;

    typedef struct packed {
        logic tx_en;
        logic rx_en;
        logic send_null;
        logic send_fct;
        logic active;
    } lout_t;

endpackage

// File: rtl/link_init_next.sv
module link_init_next
    import link_init_pkg::*;
#(
    parameter int ERR_W = 5
) (
    input  lstate_e          st_q,
    input  logic             expired,
    input  logic             link_en,
    input  logic             link_dis,
    input  logic             null_rx,
    input  logic             fct_rx,
    input  logic [ERR_W-1:0] err,
    output lstate_e          st_d
);

    logic err_any;

    assign err_any = |err;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LS_RESET: begin
                if (expired) st_d = LS_WAIT;
            end
            LS_WAIT: begin
                if (err_any)      st_d = LS_RESET;
                else if (expired) st_d = LS_READY;
            end
            LS_READY: begin
                if (err_any)      st_d = LS_RESET;
                else if (link_en) st_d = LS_START;
            end
            LS_START: begin
                if (err_any)      st_d = LS_RESET;
                else if (null_rx) st_d = LS_CONN;
                else if (expired) st_d = LS_RESET;
            end
            LS_CONN: begin
                if (err_any)      st_d = LS_RESET;
                else if (fct_rx)  st_d = LS_RUN;
                else if (expired) st_d = LS_RESET;
            end
            LS_RUN: begin
                if (err_any || link_dis) st_d = LS_RESET;
            end
            default: st_d = LS_RESET;
        endcase
    end

endmodule

// File: rtl/link_init_timer.sv
module link_init_timer
    import link_init_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int RST_CYC  = 1600,
    parameter int LONG_CYC = 3200
) (
    input  logic [CNT_W-1:0] cnt_q,
    input  lstate_e          st_q,
    input  lstate_e          st_d,
    output logic [CNT_W-1:0] cnt_d,
    output logic             expired
);

    localparam logic [CNT_W-1:0] RST_LOAD  = CNT_W'(RST_CYC - 1);
    localparam logic [CNT_W-1:0] LONG_LOAD = CNT_W'(LONG_CYC - 1);

    assign expired = (cnt_q == '0);

    always_comb begin
        if (st_d != st_q) begin
            cnt_d = (st_d == LS_RESET) ? RST_LOAD : LONG_LOAD;
        end else if (expired) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/link_init_outdec.sv
module link_init_outdec
    import link_init_pkg::*;
(
    input  lstate_e st_q,
    output lout_t   outs
);

    always_comb begin
        outs = '0;
        unique case (st_q)
            LS_RESET: outs = '0;
            LS_WAIT,
            LS_READY: outs.rx_en = 1'b1;
            LS_START: begin
                outs.tx_en     = 1'b1;
                outs.rx_en     = 1'b1;
                outs.send_null = 1'b1;
            end
            LS_CONN: begin
                outs.tx_en     = 1'b1;
                outs.rx_en     = 1'b1;
                outs.send_null = 1'b1;
                outs.send_fct  = 1'b1;
            end
            LS_RUN: begin
                outs.tx_en  = 1'b1;
                outs.rx_en  = 1'b1;
                outs.active = 1'b1;
            end
            default: outs = '0;
        endcase
    end

endmodule

// File: rtl/link_init_fsm.sv
module link_init_fsm
    import link_init_pkg::*;
#(
    parameter int CLK_MHZ = 250,
    parameter int ERR_W   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             link_en,
    input  logic             link_dis,
    input  logic             null_rx,
    input  logic             fct_rx,
    input  logic [ERR_W-1:0] err,
    output logic             tx_en,
    output logic             rx_en,
    output logic             send_null,
    output logic             send_fct,
    output logic             active
);

    localparam int RST_CYC  = CLK_MHZ * 64 / 10;
    localparam int LONG_CYC = CLK_MHZ * 128 / 10;
    localparam int CNT_W    = $clog2(LONG_CYC + 1);

    typedef struct packed {
        lstate_e          st;
        logic [CNT_W-1:0] cnt;
    } regs_t;

    regs_t            r_q;
    regs_t            r_d;
    lstate_e          st_nxt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             expired;
    lout_t            outs;

    link_init_timer #(
        .CNT_W    (CNT_W),
        .RST_CYC  (RST_CYC),
        .LONG_CYC (LONG_CYC)
    ) u_timer (
        .cnt_q   (r_q.cnt),
        .st_q    (r_q.st),
        .st_d    (st_nxt),
        .cnt_d   (cnt_nxt),
        .expired (expired)
    );

    link_init_next #(
        .ERR_W (ERR_W)
    ) u_next (
        .st_q     (r_q.st),
        .expired  (expired),
        .link_en  (link_en),
        .link_dis (link_dis),
        .null_rx  (null_rx),
        .fct_rx   (fct_rx),
        .err      (err),
        .st_d     (st_nxt)
    );

    link_init_outdec u_outdec (
        .st_q (r_q.st),
        .outs (outs)
    );

    always_comb begin
        r_d     = r_q;
        r_d.st  = st_nxt;
        r_d.cnt = cnt_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st  <= LS_RESET;
            r_q.cnt <= CNT_W'(RST_CYC - 1);
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_en     = outs.tx_en;
    assign rx_en     = outs.rx_en;
    assign send_null = outs.send_null;
    assign send_fct  = outs.send_fct;
    assign active    = outs.active;

endmodule

// File: rtl/link_init_fsm_chk.sv
module link_init_fsm_chk #(
    parameter int CLK_MHZ = 250,
    parameter int ERR_W   = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             link_en,
    input logic             link_dis,
    input logic             null_rx,
    input logic             fct_rx,
    input logic [ERR_W-1:0] err,
    input logic             tx_en,
    input logic             rx_en,
    input logic             send_null,
    input logic             send_fct,
    input logic             active
);

    localparam int RST_CYC = CLK_MHZ * 64 / 10;
    localparam int LO_W    = $clog2(RST_CYC + 2);

    logic [LO_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst)        lo_q <= '0;
        else if (rx_en) lo_q <= '0;
        else            lo_q <= lo_q + 1'b1;
    end

    assert_reset_len_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_en) |-> (lo_q == LO_W'(RST_CYC)));

    assert_tx_needs_permit_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> $past(link_en));

    assert_fct_stage_needs_null_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(send_fct) |-> $past(null_rx));

    assert_run_needs_fct_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(fct_rx));

    assert_run_outputs_R8: assert property (@(posedge clk) disable iff (rst)
        active |-> (tx_en && rx_en && !send_null && !send_fct));

    assert_error_drops_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_en && (|err)) |=> !rx_en);

    assert_disable_drops_R10: assert property (@(posedge clk) disable iff (rst)
        (active && link_dis) |=> (!active && !rx_en));

endmodule

bind link_init_fsm link_init_fsm_chk #(
    .CLK_MHZ (CLK_MHZ),
    .ERR_W   (ERR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .link_en   (link_en),
    .link_dis  (link_dis),
    .null_rx   (null_rx),
    .fct_rx    (fct_rx),
    .err       (err),
    .tx_en     (tx_en),
    .rx_en     (rx_en),
    .send_null (send_null),
    .send_fct  (send_fct),
    .active    (active)
);

// File: tb/link_init_fsm_tb.sv
module link_init_fsm_tb;

    localparam int CLK_MHZ = 20;
    localparam int ERR_W   = 5;
    localparam int RST     = CLK_MHZ * 64 / 10;
    localparam int LONG    = CLK_MHZ * 128 / 10;
    localparam int NV      = 40;

    typedef struct packed {
        logic             le;
        logic             ld;
        logic             nr;
        logic             fr;
        logic [ERR_W-1:0] er;
        logic [15:0]      n;
        logic [4:0]       exp;
        logic [3:0]       req;
    } vec_t;

    // exp order: {tx_en, rx_en, send_null, send_fct, active}
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b0,1'b0,1'b0,5'd0,      16'(RST-1), 5'b00000, 4'd2},  // R2 still quiet
        '{1'b0,1'b0,1'b0,1'b0,5'd0,      16'd1,      5'b01000, 4'd2},  // R2 listen
        '{1'b1,1'b0,1'b0,1'b0,5'd0,      16'(LONG-1),5'b01000, 4'd3},  // R3 link_en ignored
        '{1'b1,1'b0,1'b0,1'b0,5'd0,      16'd1,      5'b01000, 4'd3},  // R3 now permit
        '{1'b1,1'b0,1'b0,1'b0,5'd0,      16'd1,      5'b11100, 4'd4},  // R4 to NULL stage
        '{1'b0,1'b0,1'b0,1'b0,5'd0,      16'(LONG-1),5'b11100, 4'd5},  // R5 holds
        '{1'b0,1'b0,1'b1,1'b0,5'd0,      16'd1,      5'b11110, 4'd11}, // R11 null on expiry edge
        '{1'b0,1'b0,1'b0,1'b0,5'd0,      16'(LONG-1),5'b11110, 4'd7},  // R7 holds
        '{1'b0,1'b0,1'b0,1'b0,5'd0,      16'd1,      5'b00000, 4'd7},  // R7 timeout
        '{1'b0,1'b0,1'b0,1'b0,5'd0,      16'(RST),   5'b01000, 4'd2},  // R2 reentry length
        '{1'b0,1'b0,1'b0,1'b0,5'd0,      16'(LONG),  5'b01000, 4'd3},
        '{1'b0,1'b0,1'b0,1'b0,5'd0,      16'd500,    5'b01000, 4'd4},  // R4 waits
        '{1'b1,1'b0,1'b0,1'b0,5'd0,      16'd1,      5'b11100, 4'd4},
        '{1'b0,1'b0,1'b0,1'b1,5'd0,      16'd3,      5'b11100, 4'd11}, // R11 fct ignored
        '{1'b0,1'b1,1'b0,1'b0,5'd0,      16'd2,      5'b11100, 4'd10}, // R10 disable ignored
        '{1'b0,1'b0,1'b1,1'b0,5'd0,      16'd1,      5'b11110, 4'd5},  // R5 null advances
        '{1'b0,1'b0,1'b0,1'b1,5'd0,      16'd1,      5'b11001, 4'd7},  // R7 fct to run
        '{1'b0,1'b0,1'b0,1'b0,5'd0,      16'd1000,   5'b11001, 4'd8},  // R8 stays
        '{1'b0,1'b0,1'b0,1'b0,5'b00100,  16'd1,      5'b00000, 4'd9},  // R9 run error
        '{1'b0,1'b0,1'b0,1'b0,5'd0,      16'(RST),   5'b01000, 4'd2},
        '{1'b0,1'b0,1'b0,1'b0,5'b00001,  16'd1,      5'b00000, 4'd9},  // R9 listen error
        '{1'b0,1'b0,1'b0,1'b0,5'd0,      16'(RST),   5'b01000, 4'd2},
        '{1'b0,1'b0,1'b0,1'b0,5'd0,      16'(LONG),  5'b01000, 4'd3},
        '{1'b0,1'b0,1'b0,1'b0,5'b10000,  16'd1,      5'b00000, 4'd9},  // R9 permit error
        '{1'b0,1'b0,1'b0,1'b0,5'd0,      16'(RST),   5'b01000, 4'd2},
        '{1'b0,1'b0,1'b0,1'b0,5'd0,      16'(LONG),  5'b01000, 4'd3},
        '{1'b1,1'b0,1'b0,1'b0,5'd0,      16'd1,      5'b11100, 4'd4},
        '{1'b0,1'b0,1'b0,1'b0,5'd0,      16'(LONG-1),5'b11100, 4'd6},  // R6 last cycle
        '{1'b0,1'b0,1'b0,1'b0,5'd0,      16'd1,      5'b00000, 4'd6},  // R6 timeout
        '{1'b0,1'b0,1'b0,1'b0,5'd0,      16'(RST),   5'b01000, 4'd2},
        '{1'b0,1'b0,1'b0,1'b0,5'd0,      16'(LONG),  5'b01000, 4'd3},
        '{1'b1,1'b0,1'b0,1'b0,5'd0,      16'd1,      5'b11100, 4'd4},
        '{1'b0,1'b0,1'b1,1'b0,5'd0,      16'd1,      5'b11110, 4'd5},
        '{1'b0,1'b0,1'b0,1'b0,5'b01000,  16'd1,      5'b00000, 4'd9},  // R9 FCT stage error
        '{1'b0,1'b0,1'b0,1'b0,5'd0,      16'(RST),   5'b01000, 4'd2},
        '{1'b0,1'b0,1'b0,1'b0,5'd0,      16'(LONG),  5'b01000, 4'd3},
        '{1'b1,1'b0,1'b0,1'b0,5'd0,      16'd1,      5'b11100, 4'd4},
        '{1'b0,1'b0,1'b1,1'b0,5'd0,      16'd1,      5'b11110, 4'd5},
        '{1'b0,1'b0,1'b0,1'b1,5'd0,      16'd1,      5'b11001, 4'd7},
        '{1'b0,1'b1,1'b0,1'b0,5'd0,      16'd1,      5'b00000, 4'd10}  // R10 disable in run
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             link_en = 1'b0;
    logic             link_dis = 1'b0;
    logic             null_rx = 1'b0;
    logic             fct_rx = 1'b0;
    logic [ERR_W-1:0] err = '0;
    logic             tx_en, rx_en, send_null, send_fct, active;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    link_init_fsm #(
        .CLK_MHZ (CLK_MHZ),
        .ERR_W   (ERR_W)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .link_en   (link_en),
        .link_dis  (link_dis),
        .null_rx   (null_rx),
        .fct_rx    (fct_rx),
        .err       (err),
        .tx_en     (tx_en),
        .rx_en     (rx_en),
        .send_null (send_null),
        .send_fct  (send_fct),
        .active    (active)
    );

    task automatic check_out(input logic [4:0] exp, input string req);
        logic [4:0] got;
        got = {tx_en, rx_en, send_null, send_fct, active};
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s at %0t: outputs=%b expected=%b", req, $time, got, exp);
        end
    endtask

    task automatic drive(input logic le, input logic ld, input logic nr,
                         input logic fr, input logic [ERR_W-1:0] er, input int n);
        link_en  = le;
        link_dis = ld;
        null_rx  = nr;
        fct_rx   = fr;
        err      = er;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_out(5'b00000, "R1 during reset");
        rst = 1'b0;
        check_out(5'b00000, "R1 after release");

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].le, TBL[i].ld, TBL[i].nr, TBL[i].fr, TBL[i].er, int'(TBL[i].n));
            check_out(TBL[i].exp, $sformatf("R%0d step %0d", TBL[i].req, i));
        end

        // directed: reset in the middle of listening
        drive(1'b0, 1'b0, 1'b0, 1'b0, '0, RST);
        check_out(5'b01000, "R2 directed");
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 1'b0, '0, 1);
        check_out(5'b00000, "R1 mid-run reset");
        rst = 1'b0;

        // directed: errors held through quiet reset do not lengthen it
        drive(1'b0, 1'b0, 1'b0, 1'b0, '1, RST - 1);
        check_out(5'b00000, "R9 err in reset");
        drive(1'b0, 1'b0, 1'b0, 1'b0, '0, 1);
        check_out(5'b01000, "R9 reset not lengthened");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, got=hang expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule